// File: doc/BRIEF.md
# DRAM Command Source Priority Arbiter

This block sits in front of a four-rank DDR2-style command bus and chooses at most one command per clock from five competing sources. The first four are request ports: a periodic refresh request, pending column accesses (read, write or precharge), incoming read row-activates and incoming write row-activates. The fifth is a scrub row-activate that the block raises itself from a programmable interval timer. The winner is the highest-priority source that is eligible in that cycle. Priority runs from refresh, to column access, to scrub activate, to read activate, to write activate. The winning command is registered onto the bus with an active-low one-hot chip-select. In a cycle with no winner the bus carries a deselect NOP.

For every bank of every rank the block keeps an open/idle flag, and it uses these flags to judge eligibility. A row-activate to an open bank is held back, and so is a read or write column access to an idle bank. A held-back source does not block lower-priority sources, which may win in that cycle.

Each request port is valid/ready. A source that is not granted sees ready low and must hold valid and its fields unchanged until ready is high. A transfer takes place in a cycle where valid and ready are both high. The matching command then appears on the bus one clock later. Ready is a combinational function of the valids, the request fields and the bank flags. The scrub target and the interval reload value are plain control inputs.

Top module: `dram_cmd_arbiter`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with no grant, the bus drives all chip-selects high and ras_n, cas_n and we_n high, with ba and addr zero.
- R2: At most one of the four ready outputs is high in a cycle, a ready is never high unless its valid is high, and no ready is high in a cycle where the scrub activate is granted.
- R3: Among the sources eligible in a cycle, the grant goes to the first one in this order: refresh, column access, scrub activate, read activate, write activate. A source that is not eligible is skipped.
- R4: A valid refresh request is always granted in its cycle. It puts a REF command on the chip-select of ref_rank.
- R5: A read, write or scrub row-activate is eligible only when its target bank is idle. When granted it issues ACT with ba equal to the bank and addr equal to the row.
- R6: A column read or write is eligible only when its target bank is open. It issues RD or WR with ba equal to the bank and addr equal to the column, zero-extended.
- R7: ACT marks its bank open. PRE marks its bank idle. REF marks every bank of its rank idle. Each change takes effect for the eligibility decision of the next cycle.
- R8: A command granted in cycle n is on the bus in cycle n+1. The encoding on {ras_n,cas_n,we_n} is ACT=011, RD=101, WR=100, PRE=010, REF=001, NOP=111.
- R9: For a command to rank r, cs_n has exactly bit r low. At most one chip-select is ever low.
- R10: The scrub counter loads scrub_reload in reset and on each scrub grant. While no scrub request is pending, it counts down once per cycle. When it is zero, the scrub request becomes pending at the next edge and stays pending until it is granted. With reload N, the first scrub ACT appears on the bus N+2 edges after reset is released, provided nothing outranks it and its bank is idle.
- R11: cas_op selects the column command: 00 is read, 01 is write, and 10 or 11 is precharge. A precharge is eligible whether or not its bank is open, and it drives addr zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | 1 | Refresh request valid |
| ref_ready | output | 1 | Refresh request accepted |
| ref_rank | input | RANK_W | Rank to refresh |
| cas_valid | input | 1 | Column request valid |
| cas_ready | output | 1 | Column request accepted |
| cas_rank | input | RANK_W | Column request rank |
| cas_bank | input | BANK_W | Column request bank |
| cas_op | input | 2 | Column operation (R11) |
| cas_col | input | COL_W | Column address |
| rd_valid | input | 1 | Read activate valid |
| rd_ready | output | 1 | Read activate accepted |
| rd_rank | input | RANK_W | Read activate rank |
| rd_bank | input | BANK_W | Read activate bank |
| rd_row | input | ROW_W | Read activate row |
| wr_valid | input | 1 | Write activate valid |
| wr_ready | output | 1 | Write activate accepted |
| wr_rank | input | RANK_W | Write activate rank |
| wr_bank | input | BANK_W | Write activate bank |
| wr_row | input | ROW_W | Write activate row |
| scrub_reload | input | SCRUB_W | Scrub interval reload value |
| scrub_rank | input | RANK_W | Scrub target rank |
| scrub_bank | input | BANK_W | Scrub target bank |
| scrub_row | input | ROW_W | Scrub target row |
| cs_n | output | NUM_RANKS | Active-low one-hot chip-selects |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ROW_W | Row or column address |

## Verification
The interesting overlaps come from the scrub timer. It can turn pending in the same cycle that a refresh or a column precharge changes the idle state of the scrub target. It can also turn pending in a cycle where a read or write activate is queued for that same bank. The bench provokes both by running a short reload interval against random traffic that is confined to two banks per rank, with refreshes frequent enough to keep reopening banks. For each case the bench uses its own priority and bank-state model to predict which ready rises and which command lands on the bus one cycle later, and it compares the two.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF
  } dram_cmd_e;

  // Source slots, index 0 wins
  localparam int SRC_REF   = 0;
  localparam int SRC_CAS   = 1;
  localparam int SRC_SCRUB = 2;
  localparam int SRC_RD    = 3;
  localparam int SRC_WR    = 4;
  localparam int NUM_SRC   = 5;

  // {ras_n, cas_n, we_n}
  function automatic logic [2:0] cmd_pins(dram_cmd_e c);
    case (c)
      CMD_ACT: return 3'b011;
      CMD_RD:  return 3'b101;
      CMD_WR:  return 3'b100;
      CMD_PRE: return 3'b010;
      CMD_REF: return 3'b001;
      default: return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/arb_prio_select.sv
module arb_prio_select #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_slot
      if (i == 0) begin : g_top
        assign gnt[i] = req[i];
      end else begin : g_rest
        assign gnt[i] = req[i] && !(|req[i-1:0]);
      end
    end
  endgenerate

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R3
  work_conserving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));

endmodule

// File: rtl/arb_scrub_timer.sv
module arb_scrub_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] reload,
  input  logic         grant,
  output logic         pend
);

  logic [W-1:0] cnt_q;
  logic         pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= reload;
      pend_q <= 1'b0;
    end else if (grant) begin
      cnt_q  <= reload;
      pend_q <= 1'b0;
    end else if (!pend_q) begin
      if (cnt_q == '0) pend_q <= 1'b1;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign pend = pend_q;

  // R10
  scrub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !grant) |=> pend_q);

  // R10
  scrub_gnt_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> pend_q);

endmodule

// File: rtl/arb_bank_tracker.sv
module arb_bank_tracker
  import dram_arb_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int NUM_BANKS = 8,
  localparam int RANK_W = $clog2(NUM_RANKS),
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  dram_cmd_e                           op,
  input  logic [RANK_W-1:0]                   rank,
  input  logic [BANK_W-1:0]                   bank,
  output logic [NUM_RANKS-1:0][NUM_BANKS-1:0] bank_open
);

  logic [NUM_RANKS-1:0][NUM_BANKS-1:0] open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= '0;
    end else begin
      case (op)
        CMD_ACT: open_q[rank][bank] <= 1'b1;
        CMD_PRE: open_q[rank][bank] <= 1'b0;
        CMD_REF: open_q[rank]       <= '0;
        default: ;
      endcase
    end
  end

  assign bank_open = open_q;

  // R7
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CMD_ACT) |=> open_q[$past(rank)][$past(bank)]);

  // R7
  ref_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CMD_REF) |=> (open_q[$past(rank)] == '0));

  // R7
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CMD_PRE) |=> !open_q[$past(rank)][$past(bank)]);

endmodule

// File: rtl/dram_cmd_arbiter.sv
module dram_cmd_arbiter
  import dram_arb_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int SCRUB_W   = 12,
  localparam int RANK_W   = $clog2(NUM_RANKS),
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_valid,
  output logic                 ref_ready,
  input  logic [RANK_W-1:0]    ref_rank,
  input  logic                 cas_valid,
  output logic                 cas_ready,
  input  logic [RANK_W-1:0]    cas_rank,
  input  logic [BANK_W-1:0]    cas_bank,
  input  logic [1:0]           cas_op,
  input  logic [COL_W-1:0]     cas_col,
  input  logic                 rd_valid,
  output logic                 rd_ready,
  input  logic [RANK_W-1:0]    rd_rank,
  input  logic [BANK_W-1:0]    rd_bank,
  input  logic [ROW_W-1:0]     rd_row,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [RANK_W-1:0]    wr_rank,
  input  logic [BANK_W-1:0]    wr_bank,
  input  logic [ROW_W-1:0]     wr_row,
  input  logic [SCRUB_W-1:0]   scrub_reload,
  input  logic [RANK_W-1:0]    scrub_rank,
  input  logic [BANK_W-1:0]    scrub_bank,
  input  logic [ROW_W-1:0]     scrub_row,
  output logic [NUM_RANKS-1:0] cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic [BANK_W-1:0]    ba,
  output logic [ROW_W-1:0]     addr
);

  logic [NUM_RANKS-1:0][NUM_BANKS-1:0] bank_open;
  logic [NUM_SRC-1:0] req, gnt;
  logic               scrub_pend;

  dram_cmd_e          nxt_cmd;
  logic [RANK_W-1:0]  nxt_rank;
  logic [BANK_W-1:0]  nxt_bank;
  logic [ROW_W-1:0]   nxt_addr;

  // Eligibility per source
  always_comb begin
    req            = '0;
    req[SRC_REF]   = ref_valid;
    req[SRC_CAS]   = cas_valid && (cas_op[1] || bank_open[cas_rank][cas_bank]);
    req[SRC_SCRUB] = scrub_pend && !bank_open[scrub_rank][scrub_bank];
    req[SRC_RD]    = rd_valid && !bank_open[rd_rank][rd_bank];
    req[SRC_WR]    = wr_valid && !bank_open[wr_rank][wr_bank];
  end

  arb_prio_select #(.N(NUM_SRC)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .gnt   (gnt)
  );

  arb_scrub_timer #(.W(SCRUB_W)) u_scrub (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (scrub_reload),
    .grant  (gnt[SRC_SCRUB]),
    .pend   (scrub_pend)
  );

  assign ref_ready = gnt[SRC_REF];
  assign cas_ready = gnt[SRC_CAS];
  assign rd_ready  = gnt[SRC_RD];
  assign wr_ready  = gnt[SRC_WR];

  // Decode the winner into a command
  always_comb begin
    nxt_cmd  = CMD_NOP;
    nxt_rank = '0;
    nxt_bank = '0;
    nxt_addr = '0;
    if (gnt[SRC_REF]) begin
      nxt_cmd  = CMD_REF;
      nxt_rank = ref_rank;
    end else if (gnt[SRC_CAS]) begin
      nxt_rank = cas_rank;
      nxt_bank = cas_bank;
      if (cas_op[1]) begin
        nxt_cmd = CMD_PRE;
      end else begin
        nxt_cmd  = cas_op[0] ? CMD_WR : CMD_RD;
        nxt_addr = ROW_W'(cas_col);
      end
    end else if (gnt[SRC_SCRUB]) begin
      nxt_cmd  = CMD_ACT;
      nxt_rank = scrub_rank;
      nxt_bank = scrub_bank;
      nxt_addr = scrub_row;
    end else if (gnt[SRC_RD]) begin
      nxt_cmd  = CMD_ACT;
      nxt_rank = rd_rank;
      nxt_bank = rd_bank;
      nxt_addr = rd_row;
    end else if (gnt[SRC_WR]) begin
      nxt_cmd  = CMD_ACT;
      nxt_rank = wr_rank;
      nxt_bank = wr_bank;
      nxt_addr = wr_row;
    end
  end

  arb_bank_tracker #(.NUM_RANKS(NUM_RANKS), .NUM_BANKS(NUM_BANKS)) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (nxt_cmd),
    .rank      (nxt_rank),
    .bank      (nxt_bank),
    .bank_open (bank_open)
  );

  // Registered command bus
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_n                 <= '1;
      {ras_n, cas_n, we_n} <= 3'b111;
      ba                   <= '0;
      addr                 <= '0;
    end else begin
      cs_n                 <= (nxt_cmd == CMD_NOP) ? '1 : ~(NUM_RANKS'(1) << nxt_rank);
      {ras_n, cas_n, we_n} <= cmd_pins(nxt_cmd);
      ba                   <= nxt_bank;
      addr                 <= nxt_addr;
    end
  end

  // R1
  idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == '1) |-> (ras_n && cas_n && we_n));

  // R2
  rdy_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_ready || ref_valid) && (!cas_ready || cas_valid) &&
    (!rd_ready || rd_valid) && (!wr_ready || wr_valid));

  // R4
  refresh_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |-> ref_ready);

  // R5
  act_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> !bank_open[rd_rank][rd_bank]);

  // R6
  cas_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_ready && !cas_op[1]) |-> bank_open[cas_rank][cas_bank]);

  // R8
  ref_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ready |=> (!ras_n && !cas_n && we_n));

  // R8
  act_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> (!ras_n && cas_n && we_n && ba == $past(rd_bank) && addr == $past(rd_row)));

  // R9
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

endmodule

// File: tb/test_dram_cmd_arbiter.sv
`timescale 1ns/100ps
module test_dram_cmd_arbiter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_v = 0, cas_v = 0, rd_v = 0, wr_v = 0;
  logic        ref_rdy, cas_rdy, rd_rdy, wr_rdy;
  logic [1:0]  ref_r = 0, cas_r = 0, rd_r = 0, wr_r = 0, scr_r = 0;
  logic [2:0]  cas_b = 0, rd_b = 0, wr_b = 0, scr_b = 0;
  logic [1:0]  cas_op = 0;
  logic [9:0]  cas_col = 0;
  logic [13:0] rd_row = 0, wr_row = 0, scr_row = 0;
  logic [11:0] reload = 12'hFFF;
  logic [3:0]  cs_n;
  logic        ras_n, cas_n, we_n;
  logic [2:0]  ba;
  logic [13:0] addr;

  int total = 0, fails = 0;
  bit done = 0;

  // Bench model
  bit  open_m [4][8];
  int  scnt;
  bit  spend;
  int  pe_cmd;            // 0 NOP 1 ACT 2 RD 3 WR 4 PRE 5 REF
  logic [1:0]  pe_rank;
  logic [2:0]  pe_bank;
  logic [13:0] pe_addr;

  always #2.5 clk = ~clk;

  dram_cmd_arbiter i_dram_cmd_arbiter (
    .clk(clk), .rst_n(rst_n),
    .ref_valid(ref_v), .ref_ready(ref_rdy), .ref_rank(ref_r),
    .cas_valid(cas_v), .cas_ready(cas_rdy), .cas_rank(cas_r), .cas_bank(cas_b),
    .cas_op(cas_op), .cas_col(cas_col),
    .rd_valid(rd_v), .rd_ready(rd_rdy), .rd_rank(rd_r), .rd_bank(rd_b), .rd_row(rd_row),
    .wr_valid(wr_v), .wr_ready(wr_rdy), .wr_rank(wr_r), .wr_bank(wr_b), .wr_row(wr_row),
    .scrub_reload(reload), .scrub_rank(scr_r), .scrub_bank(scr_b), .scrub_row(scr_row),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_bus();
    logic [2:0] p;
    logic [3:0] c;
    logic [2:0] b;
    logic [13:0] a;
    c = ~(4'b1 << pe_rank);
    b = pe_bank;
    a = pe_addr;
    case (pe_cmd)
      1: p = 3'b011;
      2: p = 3'b101;
      3: p = 3'b100;
      4: begin p = 3'b010; a = '0; end
      5: begin p = 3'b001; b = '0; a = '0; end
      default: begin p = 3'b111; c = 4'hF; b = '0; a = '0; end
    endcase
    return {c, p, b, a};
  endfunction

  function automatic string bus_tag();
    case (pe_cmd)
      1: return "R5 R8 R9 ACT";
      2, 3: return "R6 R8 R9 RD/WR";
      4: return "R11 R8 R9 PRE";
      5: return "R4 R8 R9 REF";
      default: return "R1 NOP";
    endcase
  endfunction

  // Called just after inputs are driven at a negedge
  task automatic step(string rtag);
    bit [4:0] el;
    int g;
    #1;
    check(bus_tag(), 32'({cs_n, ras_n, cas_n, we_n, ba, addr}), 32'(exp_bus()));
    el[0] = ref_v;
    el[1] = cas_v && (cas_op[1] || open_m[cas_r][cas_b]);
    el[2] = spend && !open_m[scr_r][scr_b];
    el[3] = rd_v && !open_m[rd_r][rd_b];
    el[4] = wr_v && !open_m[wr_r][wr_b];
    g = -1;
    for (int i = 4; i >= 0; i--) if (el[i]) g = i;
    check(rtag, 32'({wr_rdy, rd_rdy, cas_rdy, ref_rdy}),
          32'({g == 4, g == 3, g == 1, g == 0}));
    pe_cmd = 0; pe_rank = 0; pe_bank = 0; pe_addr = 0;
    case (g)
      0: begin pe_cmd = 5; pe_rank = ref_r; end
      1: begin
        pe_rank = cas_r; pe_bank = cas_b;
        if (cas_op[1]) pe_cmd = 4;
        else begin pe_cmd = cas_op[0] ? 3 : 2; pe_addr = 14'(cas_col); end
      end
      2: begin pe_cmd = 1; pe_rank = scr_r; pe_bank = scr_b; pe_addr = scr_row; end
      3: begin pe_cmd = 1; pe_rank = rd_r; pe_bank = rd_b; pe_addr = rd_row; end
      4: begin pe_cmd = 1; pe_rank = wr_r; pe_bank = wr_b; pe_addr = wr_row; end
      default: ;
    endcase
    if (pe_cmd == 1) open_m[pe_rank][pe_bank] = 1;
    if (pe_cmd == 4) open_m[pe_rank][pe_bank] = 0;
    if (pe_cmd == 5) for (int b = 0; b < 8; b++) open_m[pe_rank][b] = 0;
    if (g == 2) begin spend = 0; scnt = reload; end
    else if (!spend) begin
      if (scnt == 0) spend = 1; else scnt--;
    end
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    ref_v = 0; cas_v = 0; rd_v = 0; wr_v = 0;
  endtask

  task automatic do_reset(logic [11:0] rl);
    @(negedge clk);
    rst_n = 0; reload = rl; idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int r = 0; r < 4; r++) for (int b = 0; b < 8; b++) open_m[r][b] = 0;
    scnt = rl; spend = 0; pe_cmd = 0;
  endtask

  task automatic rand_inputs();
    ref_v = ($urandom % 8) == 0; ref_r = 2'($urandom);
    cas_v = 1'($urandom); cas_r = 2'($urandom); cas_b = 3'($urandom % 2);
    cas_op = 2'($urandom); cas_col = 10'($urandom);
    rd_v = 1'($urandom); rd_r = 2'($urandom); rd_b = 3'($urandom % 2); rd_row = 14'($urandom);
    wr_v = 1'($urandom); wr_r = 2'($urandom); wr_b = 3'($urandom % 2); wr_row = 14'($urandom);
    scr_r = 2'($urandom); scr_b = 3'($urandom % 2); scr_row = 14'($urandom);
  endtask

  initial begin
    #900000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    // R1: reset state then idle cycles
    do_reset(12'hFFF);
    step("R1 R2 idle");
    step("R1 R2 idle");

    // R4 R3: every source valid, refresh must win
    ref_v = 1; ref_r = 2; cas_v = 1; cas_op = 2'b10; cas_r = 1; cas_b = 5;
    rd_v = 1; rd_r = 3; rd_b = 4; rd_row = 14'h1234;
    wr_v = 1; wr_r = 0; wr_b = 1; wr_row = 14'h0ABC;
    step("R4 R3 refresh over all");
    // R3: column precharge outranks activates
    ref_v = 0;
    step("R3 R11 cas over activates");
    // R3: read activate outranks write activate
    cas_v = 0;
    step("R3 read over write");
    // R5: same bank again is open, write activate goes instead
    step("R5 R3 open bank skipped");
    wr_v = 0;
    // R6: read column to idle bank is held
    cas_v = 1; cas_op = 2'b00; cas_r = 2; cas_b = 7; cas_col = 10'h155;
    step("R6 read to idle held");
    // R6: read column to the opened bank goes
    cas_r = 3; cas_b = 4;
    step("R6 read to open bank");
    cas_op = 2'b01; cas_col = 10'h2AA;
    step("R6 R11 write to open bank");
    // R11 R7: precharge closes it; activate is then allowed
    cas_op = 2'b11;
    step("R11 precharge");
    cas_v = 0;
    step("R7 activate after precharge");
    // R7: refresh closes whole rank
    rd_v = 0; ref_v = 1; ref_r = 3;
    step("R4 R7 refresh rank");
    ref_v = 0; rd_v = 1;
    step("R7 activate after refresh");
    idle_inputs();
    step("R1 idle after traffic");
    step("R1 idle");

    // R10: scrub fires N+2 edges after release, N=3
    scr_r = 1; scr_b = 2; scr_row = 14'h2F0F;
    do_reset(12'd3);
    begin
      int seen = -1;
      for (int k = 0; k < 8; k++) begin
        #1;
        if (seen < 0 && !ras_n && cas_n && we_n && cs_n == 4'b1101) seen = k;
        step("R10 R2 scrub idle");
      end
      check("R10 first scrub edge", 32'(seen), 32'd5);
    end

    // Sweeps with short scrub intervals and random traffic
    do_reset(12'd5);
    for (int n = 0; n < 2500; n++) begin rand_inputs(); step("R2 R3 R5 R6 sweep"); end
    do_reset(12'd0);
    for (int n = 0; n < 1500; n++) begin rand_inputs(); step("R2 R3 R10 sweep"); end
    idle_inputs();
    step("R1 final");
    step("R1 final");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule